// File: doc/BRIEF.md
# Multi-View SIMD Register Bank

This block is a bank of 32 vector registers, each 128 bits wide, for a floating-point and SIMD datapath. Any register can be read or written at a width of 8, 16, 32, 64 or the full 128 bits. Every narrow view of register n is the low-order slice of register n itself, starting at bit 0. A narrow view never covers part of a neighbouring register, and two narrow registers are never packed into one wide entry.

There are two read ports and one write port. Each port carries a register index and a 3-bit view code. A write stores the data under the view's mask and clears every bit above the view. A read returns the selected view right-aligned, with zeros above it. Read data comes from registers and appears one clock after the address is sampled. A read that addresses the entry being written in the same cycle returns the newly written, masked value; a parameter can turn this forwarding off.

The bank is built so that its storage can map onto block RAM. A synchronous reset clears a per-entry valid flag rather than the storage itself, so every entry reads as zero after reset.

Top module: `simd_regbank`

## Requirements
- R1: After a synchronous active-high reset, every one of the 32 entries reads as zero on both read ports, at every view code.
- R2: View codes are 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits and 4 = 128 bits; codes 5, 6 and 7 act as 128 bits. A read returns bits [w-1:0] of the entry on rd_data[w-1:0] and drives zero above them.
- R3: A write with view width w stores wr_data[w-1:0] in bits [w-1:0] of the entry and sets bits [127:w] of that entry to zero.
- R4: A view with index n always addresses register n from bit 0. A write to index n leaves every other index unchanged, including n-1 and n+1.
- R5: Read data is registered: the address and view sampled at a rising edge set rd_data after that edge, and rd_data holds until the next edge.
- R6: When a read port samples the same index that a write samples at the same edge, the read returns the new value, masked first by the write view and then by the read view. This applies to both ports.
- R7: The two read ports work independently and can read different indices with different views in the same cycle.
- R8: When wr_en is low, no entry changes, whatever wr_idx, wr_view and wr_data carry.
- R9: A write presented while rst is high is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rd0_idx | input | 5 | Read port 0 register index |
| rd0_view | input | 3 | Read port 0 view code |
| rd0_data | output | 128 | Read port 0 data, right-aligned and zero-padded |
| rd1_idx | input | 5 | Read port 1 register index |
| rd1_view | input | 3 | Read port 1 view code |
| rd1_data | output | 128 | Read port 1 data, right-aligned and zero-padded |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register index |
| wr_view | input | 3 | Write view code |
| wr_data | input | 128 | Write data; only the low view-width bits are used |

## Verification
The hardest case to reach is a narrow write that clears upper bits set by an earlier wide write to the same entry, combined with a same-cycle read of that entry at a different view. That read must be answered by forwarding, not from storage. The stimulus table fills entries with full-width patterns and then rewrites them through narrow views. During each rewrite, port 0 reads the same index at another width while port 1 reads the neighbouring index. The next cycle reads the entry back at full width to expose any leftover upper bits.

// File: rtl/srb_pkg.sv
package srb_pkg;

  localparam int unsigned VIEW_W = 3;

  typedef enum logic [VIEW_W-1:0] {
    VIEW_B8   = 3'd0,
    VIEW_B16  = 3'd1,
    VIEW_B32  = 3'd2,
    VIEW_B64  = 3'd3,
    VIEW_B128 = 3'd4
  } view_e;

  // Number of bytes a view code covers; unknown codes select the full width.
  function automatic int unsigned view_bytes(input logic [VIEW_W-1:0] code,
                                             input int unsigned full_bytes);
    int unsigned nb;
    case (code)
      VIEW_B8:  nb = 1;
      VIEW_B16: nb = 2;
      VIEW_B32: nb = 4;
      VIEW_B64: nb = 8;
      default:  nb = full_bytes;
    endcase
    if (nb > full_bytes) nb = full_bytes;
    return nb;
  endfunction

endpackage

// File: rtl/srb_view_mask.sv
module srb_view_mask
  import srb_pkg::*;
#(
  parameter int unsigned DATA_W = 128
) (
  input  logic [VIEW_W-1:0] view,
  output logic [DATA_W-1:0] mask
);

  localparam int unsigned LANES = DATA_W / 8;

  int unsigned nbytes;
  always_comb nbytes = view_bytes(view, LANES);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mask[8*g +: 8] = {8{(g < nbytes)}};
  end

endmodule

// File: rtl/srb_storage.sv
module srb_storage #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned DATA_W = 128,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr0,
  input  logic [IDX_W-1:0]  raddr1,
  output logic [DATA_W-1:0] rq0,
  output logic [DATA_W-1:0] rq1,
  output logic              rvld0,
  output logic              rvld1
);

  // Array with no reset, so it can map onto block RAM; only the flags are reset.
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  valid;

  logic we_ok;
  assign we_ok = we && !rst;

  always_ff @(posedge clk) begin
    if (we_ok) mem[waddr] <= wdata;
    rq0 <= mem[raddr0];
    rq1 <= mem[raddr1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= '0;
      rvld0 <= 1'b0;
      rvld1 <= 1'b0;
    end else begin
      if (we_ok) valid[waddr] <= 1'b1;
      rvld0 <= valid[raddr0];
      rvld1 <= valid[raddr1];
    end
  end

endmodule

// File: rtl/srb_read_port.sv
module srb_read_port
  import srb_pkg::*;
#(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned IDX_W  = 5,
  parameter bit          BYPASS = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [VIEW_W-1:0] rd_view,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data_m,
  input  logic [DATA_W-1:0] mem_q,
  input  logic              mem_vld,
  output logic [DATA_W-1:0] rd_data
);

  logic [VIEW_W-1:0] view_q;
  logic [DATA_W-1:0] rmask;
  logic              hit_d;
  logic              hit_q;
  logic [DATA_W-1:0] fwd_q;
  logic [DATA_W-1:0] raw;

  if (BYPASS) begin : g_fwd
    assign hit_d = wr_en && (wr_idx == rd_idx);
    always_ff @(posedge clk) begin
      if (rst) begin
        hit_q <= 1'b0;
        fwd_q <= '0;
      end else begin
        hit_q <= hit_d;
        fwd_q <= wr_data_m;
      end
    end
  end else begin : g_nofwd
    assign hit_d = 1'b0;
    always_ff @(posedge clk) begin
      hit_q <= hit_d;
      fwd_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) view_q <= VIEW_B128;
    else     view_q <= rd_view;
  end

  srb_view_mask #(.DATA_W(DATA_W)) u_rmask (
    .view (view_q),
    .mask (rmask)
  );

  always_comb begin
    if (hit_q)        raw = fwd_q;
    else if (mem_vld) raw = mem_q;
    else              raw = '0;
    rd_data = raw & rmask;
  end

endmodule

// File: rtl/simd_regbank.sv
module simd_regbank
  import srb_pkg::*;
#(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned DATA_W = 128,
  parameter bit          BYPASS = 1'b1,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd0_idx,
  input  logic [VIEW_W-1:0] rd0_view,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [IDX_W-1:0]  rd1_idx,
  input  logic [VIEW_W-1:0] rd1_view,
  output logic [DATA_W-1:0] rd1_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VIEW_W-1:0] wr_view,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] wmask;
  logic [DATA_W-1:0] wdata_m;
  logic              wen;
  logic [DATA_W-1:0] q0, q1;
  logic              v0, v1;

  srb_view_mask #(.DATA_W(DATA_W)) u_wmask (
    .view (wr_view),
    .mask (wmask)
  );

  // Masked write data clears every bit above the view.
  assign wdata_m = wr_data & wmask;
  assign wen     = wr_en && !rst;

  srb_storage #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .we     (wen),
    .waddr  (wr_idx),
    .wdata  (wdata_m),
    .raddr0 (rd0_idx),
    .raddr1 (rd1_idx),
    .rq0    (q0),
    .rq1    (q1),
    .rvld0  (v0),
    .rvld1  (v1)
  );

  srb_read_port #(.DATA_W(DATA_W), .IDX_W(IDX_W), .BYPASS(BYPASS)) u_rp0 (
    .clk       (clk),
    .rst       (rst),
    .rd_idx    (rd0_idx),
    .rd_view   (rd0_view),
    .wr_en     (wen),
    .wr_idx    (wr_idx),
    .wr_data_m (wdata_m),
    .mem_q     (q0),
    .mem_vld   (v0),
    .rd_data   (rd0_data)
  );

  srb_read_port #(.DATA_W(DATA_W), .IDX_W(IDX_W), .BYPASS(BYPASS)) u_rp1 (
    .clk       (clk),
    .rst       (rst),
    .rd_idx    (rd1_idx),
    .rd_view   (rd1_view),
    .wr_en     (wen),
    .wr_idx    (wr_idx),
    .wr_data_m (wdata_m),
    .mem_q     (q1),
    .mem_vld   (v1),
    .rd_data   (rd1_data)
  );

endmodule

// File: rtl/srb_checker.sv
module srb_checker
  import srb_pkg::*;
#(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned DATA_W = 128,
  parameter bit          BYPASS = 1'b1,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst,
  input logic [IDX_W-1:0]  rd0_idx,
  input logic [VIEW_W-1:0] rd0_view,
  input logic [DATA_W-1:0] rd0_data,
  input logic [IDX_W-1:0]  rd1_idx,
  input logic [VIEW_W-1:0] rd1_view,
  input logic [DATA_W-1:0] rd1_data,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [VIEW_W-1:0] wr_view,
  input logic [DATA_W-1:0] wr_data
);

  // Shift-based mask, written independently of the lane-based mask in the design.
  function automatic logic [DATA_W-1:0] cmask(input logic [VIEW_W-1:0] c);
    int unsigned bits;
    bits = 8 * view_bytes(c, DATA_W / 8);
    return ~({DATA_W{1'b1}} << bits);
  endfunction

  // R1: first cycle out of reset shows zero on both ports
  p_rst_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rd0_data == '0 && rd1_data == '0));

  // R2: bits above the sampled read view are zero
  p_pad_port0_r2: assert property (@(posedge clk) disable iff (rst)
    (rd0_data & ~cmask($past(rd0_view))) == '0);

  p_pad_port1_r2: assert property (@(posedge clk) disable iff (rst)
    (rd1_data & ~cmask($past(rd1_view))) == '0);

  if (BYPASS) begin : g_fwd_chk
    // R6: same-edge write and read of one index return the new masked value
    p_fwd_port0_r6: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_idx == rd0_idx) |=>
        rd0_data == ($past(wr_data) & cmask($past(wr_view)) & cmask($past(rd0_view))));

    p_fwd_port1_r6: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_idx == rd1_idx) |=>
        rd1_data == ($past(wr_data) & cmask($past(wr_view)) & cmask($past(rd1_view))));
  end

endmodule

bind simd_regbank srb_checker #(
  .DEPTH  (DEPTH),
  .DATA_W (DATA_W),
  .BYPASS (BYPASS)
) u_srb_checker (.*);

// File: tb/tb_simd_regbank.sv
module tb_simd_regbank;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic [4:0]   rd0_idx, rd1_idx, wr_idx;
  logic [2:0]   rd0_view, rd1_view, wr_view;
  logic [127:0] rd0_data, rd1_data, wr_data;
  logic         wr_en;

  int n_checks = 0;
  int n_fail   = 0;

  logic [127:0] refm [32];

  // Stimulus table: write index, write view, write data, read view on port 0.
  localparam logic [4:0] T_IDX [NV] = '{5'd2, 5'd2, 5'd3, 5'd1, 5'd31, 5'd0, 5'd3, 5'd16, 5'd17, 5'd2};
  localparam logic [2:0] T_WV  [NV] = '{3'd4, 3'd3, 3'd4, 3'd4, 3'd7, 3'd4, 3'd2, 3'd1, 3'd0, 3'd0};
  localparam logic [2:0] T_RV  [NV] = '{3'd4, 3'd4, 3'd2, 3'd3, 3'd5, 3'd0, 3'd4, 3'd3, 3'd1, 3'd4};
  localparam logic [127:0] T_DAT [NV] = '{
    128'hFEDC_BA98_7654_3210_0F1E_2D3C_4B5A_6978,
    128'h1111_2222_3333_4444_5555_6666_7777_8888,
    128'hA5A5_A5A5_A5A5_A5A5_A5A5_A5A5_A5A5_A5A5,
    128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
    128'h8000_0000_0000_0001_8000_0000_0000_0001,
    128'h0123_4567_89AB_CDEF_0123_4567_89AB_CDEF,
    128'hDEAD_BEEF_CAFE_F00D_DEAD_BEEF_CAFE_F00D,
    128'h7E7E_7E7E_7E7E_7E7E_7E7E_7E7E_7E7E_BEEF,
    128'h0000_0000_0000_0000_0000_0000_0000_00C3,
    128'h5A5A_5A5A_5A5A_5A5A_5A5A_5A5A_5A5A_5AE1
  };

  simd_regbank dut (
    .clk(clk), .rst(rst),
    .rd0_idx(rd0_idx), .rd0_view(rd0_view), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_view(rd1_view), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_view(wr_view), .wr_data(wr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // View mask built from the byte count in R2.
  function automatic logic [127:0] emask(input logic [2:0] c);
    int nb;
    logic [127:0] m;
    nb = (c == 3'd0) ? 1 : (c == 3'd1) ? 2 : (c == 3'd2) ? 4 : (c == 3'd3) ? 8 : 16;
    m = '0;
    for (int b = 0; b < 16; b++) if (b < nb) m[8*b +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs, let the edge pass, then settle.
  task automatic cyc(input logic we, input logic [4:0] wi, input logic [2:0] wv,
                     input logic [127:0] wd, input logic [4:0] r0, input logic [2:0] v0,
                     input logic [4:0] r1, input logic [2:0] v1);
    wr_en = we; wr_idx = wi; wr_view = wv; wr_data = wd;
    rd0_idx = r0; rd0_view = v0; rd1_idx = r1; rd1_view = v1;
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    cyc(1'b0, 5'd0, 3'd4, '0, 5'd0, 3'd4, 5'd0, 3'd4);
    // Fill some entries with a wide value before reset, to show that reset clears them.
    rst = 1'b0;
    cyc(1'b1, 5'd5, 3'd4, {128{1'b1}}, 5'd0, 3'd4, 5'd0, 3'd4);
    rst = 1'b1;
    // R9: this write is dropped during reset
    cyc(1'b1, 5'd6, 3'd4, {128{1'b1}}, 5'd0, 3'd4, 5'd0, 3'd4);
    cyc(1'b0, 5'd0, 3'd4, '0, 5'd0, 3'd4, 5'd0, 3'd4);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) refm[i] = '0;

    // R1: every entry reads zero after reset, both ports
    for (int i = 0; i < 32; i += 2) begin
      cyc(1'b0, 5'd0, 3'd0, '0, 5'(i), 3'd4, 5'(i+1), 3'd4);
      check("R1 port0", rd0_data, '0);
      check("R1 port1", rd1_data, '0);
    end
    cyc(1'b0, 5'd0, 3'd0, '0, 5'd6, 3'd4, 5'd5, 3'd4);
    check("R9 write during reset", rd0_data, '0);
    check("R1 pre-reset write cleared", rd1_data, '0);

    // Table walk: write + same-cycle read (R6, R3), neighbour read (R4, R7), then readback.
    for (int k = 0; k < NV; k++) begin
      logic [4:0] nb;
      nb = T_IDX[k] ^ 5'd1;
      refm[T_IDX[k]] = T_DAT[k] & emask(T_WV[k]);
      cyc(1'b1, T_IDX[k], T_WV[k], T_DAT[k], T_IDX[k], T_RV[k], nb, 3'd4);
      check("R6 same-cycle forward", rd0_data, refm[T_IDX[k]] & emask(T_RV[k]));
      check("R4 neighbour untouched", rd1_data, refm[nb]);
      cyc(1'b0, 5'd0, 3'd0, '1, T_IDX[k], 3'd4, T_IDX[k], T_RV[k]);
      check("R3 upper bits zeroed", rd0_data, refm[T_IDX[k]]);
      check("R2 view right-aligned", rd1_data, refm[T_IDX[k]] & emask(T_RV[k]));
    end

    // R2: every view code on entry 1 (all ones), including codes 5..7
    for (int c = 0; c < 8; c++) begin
      cyc(1'b0, 5'd0, 3'd0, '0, 5'd1, 3'(c), 5'd1, 3'd4);
      check("R2 view code", rd0_data, refm[1] & emask(3'(c)));
      check("R7 port1 independent", rd1_data, refm[1]);
    end

    // R8: wr_en low changes nothing
    cyc(1'b0, 5'd1, 3'd0, '0, 5'd0, 3'd4, 5'd0, 3'd4);
    cyc(1'b0, 5'd0, 3'd0, '0, 5'd1, 3'd4, 5'd3, 3'd4);
    check("R8 disabled write", rd0_data, refm[1]);

    // R5: output follows the edge, not the address
    cyc(1'b0, 5'd0, 3'd0, '0, 5'd1, 3'd4, 5'd0, 3'd4);
    rd0_idx = 5'd0; #2;
    check("R5 holds until edge", rd0_data, refm[1]);
    @(posedge clk); #1;
    check("R5 updates after edge", rd0_data, refm[0]);

    // R6 on port 1 with a narrow write over a full entry
    refm[3] = 128'h0000_0000_0000_0000_0000_0000_0000_BEEF & emask(3'd1);
    cyc(1'b1, 5'd3, 3'd1, {8{16'hBEEF}}, 5'd2, 3'd4, 5'd3, 3'd4);
    check("R6 port1 forward", rd1_data, refm[3]);
    check("R4 port0 other entry", rd0_data, refm[2]);

    finish_run();
  end

endmodule